// File: doc/BRIEF.md
# Position-Ranked Interrupt Priority Chain

This block ranks interrupt sources by where they sit in a chain. Each source has its own cell. The cells pass an enable signal from one to the next: the first cell takes the chain input, and each later cell takes the enable of the cell before it. A cell that has something pending, or that is being serviced, pulls its outgoing enable low. That blocks every cell below it, while cells above it can still raise a request and interrupt it.

The processor side sees a single active-low request line, a one-cycle acknowledge input and a one-cycle return strobe. During the acknowledge, the one cell that is allowed to request places its vector on the data output, and from the next clock edge on it is in service. A return strobe ends service for the in-service cell that currently has its enable high, which is the highest active cell. Any nested lower cell stays in service, and lower requests that were held back then come through in order.

Each cell holds a writable vector register, and bit 0 of each vector always reads as zero. The enable chain is combinational, so it settles within the acknowledge cycle.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset no cell is in service, `irq_n_o` is high and `data_vld_o` is low while nothing is pending, and the vector of cell i is 2*i.
- R2: Cell i requests only when `pend_i[i]` is high, its incoming enable is high and it is not in service. `irq_n_o` is low exactly when some cell requests.
- R3: The outgoing enable of a cell is its incoming enable AND NOT (pending OR in service). `chain_en_o` is the outgoing enable of the last cell (index N-1) and follows the inputs in the same cycle.
- R4: In a cycle with `ack_i` high, the requesting cell (index 0 ranks highest) drives its vector on `data_o` and `data_vld_o` is high. With no owner, `data_o` is 0 and `data_vld_o` is low.
- R5: A write through `vec_wr_i[i]` stores `vec_wdata_i` into cell i with bit 0 cleared.
- R6: The cell that owns an acknowledge is in service from the next edge on. It keeps every lower cell blocked, even after its pending input falls, until a return strobe clears it.
- R7: A higher cell that becomes pending while a lower cell is in service requests and can be acknowledged (nesting).
- R8: On `reti_i`, only an in-service cell whose incoming enable is high leaves service. In-service cells further down stay in service, and held lower requests then appear.
- R9: With `chain_en_i` low, no cell requests and an acknowledge is ignored.
- R10: A vector write and an acknowledge to the same cell in one cycle deliver the old vector. The new vector is used from the next acknowledge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_en_i | input | 1 | Enable into cell 0 (tie high at the head of the chain) |
| pend_i | input | N | Per-cell local pending level |
| ack_i | input | 1 | Acknowledge cycle, one clock wide |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_wr_i | input | N | Per-cell vector write enable |
| vec_wdata_i | input | W | Vector write data |
| irq_n_o | output | 1 | Combined active-low request |
| data_o | output | W | Vector of the acknowledged cell, else 0 |
| data_vld_o | output | 1 | High while a cell owns the acknowledge |
| chain_en_o | output | 1 | Enable out of the last cell |

## Verification
Two functions can fall in one cycle: a vector write and the acknowledge of that same cell. The bench provokes this directly. It expects the old vector on `data_o` in that cycle and the new vector at the next acknowledge once the cell has been returned. The random phase also mixes writes, acknowledges and return strobes freely. A bench model of in-service state and vectors, derived from the requirements, judges every cycle, including return strobes that coincide with nested service.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Spacing between reset vectors of adjacent cells; keeps bit 0 clear.
  localparam int unsigned IRQ_VEC_STEP = 2;

  function automatic int unsigned irq_rst_vec(input int unsigned idx);
    return idx * IRQ_VEC_STEP;
  endfunction
endpackage

// File: rtl/irq_prio_cell.sv
module irq_prio_cell #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VEC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_in,
  input  logic         pend,
  input  logic         ack,
  input  logic         reti,
  input  logic         vec_wr,
  input  logic [W-1:0] vec_wdata,
  output logic         en_out,
  output logic         req,
  output logic         grant,
  output logic [W-1:0] vec_q
);
  logic svc_q;

  assign req    = en_in & pend & ~svc_q;
  assign en_out = en_in & ~(pend | svc_q);
  assign grant  = ack & req;

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_q <= 1'b0;
      vec_q <= RST_VEC;
    end else begin
      if (grant)
        svc_q <= 1'b1;
      else if (reti && en_in && svc_q)
        svc_q <= 1'b0;
      if (vec_wr)
        vec_q <= {vec_wdata[W-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   grant,
  input  logic [N*W-1:0] vec_flat,
  output logic [W-1:0]   data,
  output logic           vld
);
  always_comb begin
    data = '0;
    for (int i = 0; i < N; i++)
      data = data | ({W{grant[i]}} & vec_flat[i*W +: W]);
  end
  assign vld = |grant;
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chain_en_i,
  input  logic [N-1:0] pend_i,
  input  logic         ack_i,
  input  logic         reti_i,
  input  logic [N-1:0] vec_wr_i,
  input  logic [W-1:0] vec_wdata_i,
  output logic         irq_n_o,
  output logic [W-1:0] data_o,
  output logic         data_vld_o,
  output logic         chain_en_o
);
  logic [N:0]     en_link;
  logic [N-1:0]   req_v;
  logic [N-1:0]   grant_v;
  logic [N*W-1:0] vec_flat;

  assign en_link[0] = chain_en_i;

  for (genvar g = 0; g < N; g++) begin : g_cell
    localparam logic [W-1:0] CELL_RST_VEC = W'(irq_pkg::irq_rst_vec(g));
    irq_prio_cell #(.W(W), .RST_VEC(CELL_RST_VEC)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .en_in    (en_link[g]),
      .pend     (pend_i[g]),
      .ack      (ack_i),
      .reti     (reti_i),
      .vec_wr   (vec_wr_i[g]),
      .vec_wdata(vec_wdata_i),
      .en_out   (en_link[g+1]),
      .req      (req_v[g]),
      .grant    (grant_v[g]),
      .vec_q    (vec_flat[g*W +: W])
    );
  end

  irq_vec_mux #(.N(N), .W(W)) u_mux (
    .grant   (grant_v),
    .vec_flat(vec_flat),
    .data    (data_o),
    .vld     (data_vld_o)
  );

  assign irq_n_o    = ~|req_v;
  assign chain_en_o = en_link[N];
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         chain_en_i,
  input logic [N-1:0] pend_i,
  input logic         ack_i,
  input logic         irq_n_o,
  input logic [W-1:0] data_o,
  input logic         data_vld_o,
  input logic         chain_en_o
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst) (pend_i == '0) |-> irq_n_o); // R2
  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (rst) (|pend_i) |-> !chain_en_o); // R3
  AST_VLD_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst) data_vld_o |-> (ack_i && !irq_n_o)); // R4
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst) !data_vld_o |-> (data_o == '0)); // R4
  AST_VEC_EVEN: assert property (@(posedge clk) disable iff (rst) data_vld_o |-> !data_o[0]); // R5
  AST_OWNER_BLOCKS: assert property (@(posedge clk) disable iff (rst) data_vld_o |=> !chain_en_o); // R6
  AST_CHAIN_OFF: assert property (@(posedge clk) disable iff (rst) !chain_en_i |-> (irq_n_o && !data_vld_o && !chain_en_o)); // R9
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/tb_irq_daisy_chain.sv
module tb_irq_daisy_chain;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         chain_en_i;
  logic [N-1:0] pend_i;
  logic         ack_i;
  logic         reti_i;
  logic [N-1:0] vec_wr_i;
  logic [W-1:0] vec_wdata_i;
  logic         irq_n_o;
  logic [W-1:0] data_o;
  logic         data_vld_o;
  logic         chain_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [N-1:0] m_svc;
  logic [W-1:0] m_vec [N];

  always #2 clk = ~clk;

  irq_daisy_chain #(.N(N), .W(W)) dut (.*);

  task automatic check(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [N:0] en_chain(logic [N-1:0] p, logic en);
    logic [N:0] e;
    e[0] = en;
    for (int i = 0; i < N; i++) e[i+1] = e[i] & ~(p[i] | m_svc[i]);
    return e;
  endfunction

  task automatic step(logic [N-1:0] p, logic a, logic r, logic [N-1:0] wr,
                      logic [W-1:0] wd, logic en, string tag);
    logic [N:0]   e;
    logic [N-1:0] req, nsvc;
    int           g;
    logic [W-1:0] exp_d;
    @(negedge clk);
    pend_i = p; ack_i = a; reti_i = r; vec_wr_i = wr; vec_wdata_i = wd; chain_en_i = en;
    #1;
    e   = en_chain(p, en);
    req = p & ~m_svc & e[N-1:0];
    g   = -1;
    for (int i = 0; i < N; i++) if (a && req[i] && g < 0) g = i;
    exp_d = (g >= 0) ? m_vec[g] : '0;
    check((tag == "") ? "R2" : tag, int'(irq_n_o), int'(~|req));
    check((tag == "") ? "R3" : tag, int'(chain_en_o), int'(e[N]));
    check((tag == "") ? "R4" : tag, int'(data_vld_o), int'(g >= 0));
    check((tag == "") ? "R4" : tag, int'(data_o), int'(exp_d));
    nsvc = m_svc;
    if (g >= 0) nsvc[g] = 1'b1;
    if (r) for (int i = 0; i < N; i++) if (m_svc[i] && e[i]) nsvc[i] = 1'b0;
    @(posedge clk);
    m_svc = nsvc;
    for (int i = 0; i < N; i++) if (wr[i]) m_vec[i] = {wd[W-1:1], 1'b0};
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1'b1; chain_en_i = 1'b1; pend_i = '0; ack_i = 0; reti_i = 0;
    vec_wr_i = '0; vec_wdata_i = '0;
    m_svc = '0;
    for (int i = 0; i < N; i++) m_vec[i] = W'(2 * i);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R1", int'(irq_n_o), 1);
    check("R1", int'(data_vld_o), 0);
    check("R1", int'(chain_en_o), 1);
    @(negedge clk); rst = 1'b0;

    // R1: reset state and reset vector of cell 3
    step(4'b0000, 0, 0, 4'b0000, 8'h00, 1, "R1");
    step(4'b1000, 1, 0, 4'b0000, 8'h00, 1, "R1");
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R1");

    // R5: write with bit 0 set, read back on acknowledge
    step(4'b0000, 0, 0, 4'b0010, 8'h55, 1, "R5");
    step(4'b0010, 1, 0, 4'b0000, 8'h00, 1, "R5");
    check("R5", int'(m_vec[1]), 8'h54);
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R5");

    // R10: write and acknowledge of the same cell in one cycle
    step(4'b0100, 1, 0, 4'b0100, 8'hA1, 1, "R10");
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R10");
    step(4'b0100, 1, 0, 4'b0000, 8'h00, 1, "R10");
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R10");

    // R6 / R7 / R8: nesting
    step(4'b0100, 1, 0, 4'b0000, 8'h00, 1, "R6");
    step(4'b1000, 0, 0, 4'b0000, 8'h00, 1, "R6");
    step(4'b1001, 0, 0, 4'b0000, 8'h00, 1, "R7");
    step(4'b1001, 1, 0, 4'b0000, 8'h00, 1, "R7");
    step(4'b1000, 0, 1, 4'b0000, 8'h00, 1, "R8");
    step(4'b1000, 0, 0, 4'b0000, 8'h00, 1, "R8");
    step(4'b1000, 0, 1, 4'b0000, 8'h00, 1, "R8");
    step(4'b1000, 1, 0, 4'b0000, 8'h00, 1, "R8");
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R8");

    // R9: chain disabled ignores acknowledge
    step(4'b0001, 1, 0, 4'b0000, 8'h00, 0, "R9");
    step(4'b0001, 0, 0, 4'b0000, 8'h00, 1, "R9");
    step(4'b0001, 1, 0, 4'b0000, 8'h00, 1, "R9");
    step(4'b0000, 0, 1, 4'b0000, 8'h00, 1, "R9");

    // Random mix
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] p, wr;
      for (int i = 0; i < N; i++) p[i] = ($urandom % 10) < 3;
      wr = '0;
      if (($urandom % 20) == 0) wr[$urandom % N] = 1'b1;
      step(p, ($urandom % 4) == 0, ($urandom % 5) == 0, wr, W'($urandom),
           ($urandom % 10) != 0, "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule